// File: doc/BRIEF.md
# Hebbian Training Iteration Sequencer

This block runs one pass of generalized Hebbian learning over a set of neurons. It does no arithmetic itself. It holds the storage around two external arithmetic units. The first is a dot-product unit that forms the output y of each neuron. The second is an update unit that forms each neuron's new weights and its outgoing residual. The block holds three stores: a training-vector buffer split into lanes, a first-in-first-out residual buffer, and a two-port weight RAM. It streams segments to both units and writes the new weights back.

Each vector has `SEGS` segments of `LANES` elements. Element `k*LANES + l` sits in lane `l` of segment `k`, at bits `[l*DW +: DW]` of every segment-wide bus. An iteration moves through phases 0 to `NEURONS`. In phase `s`, the dot-product stream for neuron `s` and the update stream for neuron `s-1` run in the same cycles, segment by segment. A phase ends when the next y has arrived and every update result is back.

The sequencer states are IDLE, STREAM, DRAIN and FINISH. The transitions are:
- start-accept: IDLE to STREAM.
- last-segment-issued: STREAM to DRAIN.
- next-phase: DRAIN to STREAM.
- final-phase-drained: DRAIN to FINISH.
- pulse-done: FINISH to IDLE.

Top module: `gha_iter_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `dp_valid` and `up_valid` are all low.
- R2: `start` is acted on only while `busy` is low. While busy, `start`, `x_ld_en` and `w_ld_en` have no effect: no second iteration runs, and the stored vector and weights stay unchanged.
- R3: For each neuron j (0-based, in ascending order), the dot-product stream presents segments k = 0 to SEGS-1 in order. Each beat carries training segment k on `dp_x` and the weights from RAM address j*SEGS+k on `dp_w`. `dp_first` is high only when k = 0, and `dp_last` only when k = SEGS-1.
- R4: No update beat for neuron j is issued before `dp_y_valid` has delivered y_j. `up_y` carries y_j and is held through the neuron's update stream.
- R5: While neuron j is being updated, segment k of that update shares a cycle with segment k of the dot-product stream for neuron j+1.
- R6: The residual input `up_z` for neuron 0 is the training vector. For any later neuron it is the residual returned for the previous neuron, replayed in the order it was returned.
- R7: The residual buffer holds SEGS segments and never overflows or underflows. The residual of the last neuron is not stored.
- R8: The n-th result returned for neuron j (`up_res_valid`) is written to RAM address j*SEGS+n. The next iteration uses it as neuron j's weights.
- R9: `done` is high for exactly one cycle per iteration, after the last weight write of neuron NEURONS-1. `busy` is low in the next cycle.
- R10: While idle, `w_ld_en` writes `w_ld_data` to address `w_ld_addr` (j*SEGS+k) and `x_ld_en` writes training segment `x_ld_seg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an iteration |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle end-of-iteration pulse |
| x_ld_en | input | 1 | Load one training segment |
| x_ld_seg | input | KW | Segment index to load |
| x_ld_data | input | LANES*DW | Segment data, lane l at [l*DW +: DW] |
| w_ld_en | input | 1 | Preload one weight segment |
| w_ld_addr | input | AW | Weight address j*SEGS+k |
| w_ld_data | input | LANES*DW | Weight segment data |
| dp_valid | output | 1 | Dot-product beat valid |
| dp_first | output | 1 | First segment of a neuron |
| dp_last | output | 1 | Last segment of a neuron |
| dp_neuron | output | PHW | Neuron of the beat |
| dp_seg | output | KW | Segment of the beat |
| dp_x | output | LANES*DW | Training segment |
| dp_w | output | LANES*DW | Weight segment |
| dp_y_valid | input | 1 | Neuron output ready |
| dp_y | input | DW | Neuron output value |
| up_valid | output | 1 | Update beat valid |
| up_neuron | output | PHW | Neuron being updated |
| up_seg | output | KW | Segment of the beat |
| up_z | output | LANES*DW | Incoming residual segment |
| up_w | output | LANES*DW | Old weight segment |
| up_y | output | DW | Output of the neuron being updated |
| up_res_valid | input | 1 | Update result ready |
| up_w_new | input | LANES*DW | New weight segment |
| up_z_new | input | LANES*DW | Outgoing residual segment |

## Verification
Two functions coincide every cycle of the middle phases: the dot-product stream of neuron j+1 and the update stream of neuron j. In those cycles the weight RAM write port and the residual buffer's push side are also busy with results still returning from the earlier beats. The bench provokes this with table rows that vary the latencies of the two arithmetic models. These rows make the y hand-off and the result write-back land at different points relative to the next stream. It judges the overlap by counting beats in which both streams are valid for neighbouring neurons at equal segments. It checks correctness through the data each stream carries and through the weights the following iteration reads back.

// File: rtl/gha_pkg.sv
package gha_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_DRAIN,
        ST_FINISH
    } gha_state_e;

    function automatic int gha_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/gha_wram.sv
module gha_wram #(
    parameter int DEPTH = 12,
    parameter int W     = 32,
    localparam int AW   = gha_pkg::gha_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/gha_vec_buf.sv
module gha_vec_buf #(
    parameter int LANES = 2,
    parameter int SEGS  = 4,
    parameter int DW    = 16,
    localparam int KW   = gha_pkg::gha_bits(SEGS),
    localparam int LW   = LANES * DW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [KW-1:0] wseg,
    input  logic [LW-1:0] wdata,
    input  logic [KW-1:0] rseg,
    output logic [LW-1:0] rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DW-1:0] sub [SEGS];

        always_ff @(posedge clk) begin
            if (we) begin
                sub[wseg] <= wdata[l*DW +: DW];
            end
        end

        assign rdata[l*DW +: DW] = sub[rseg];
    end

endmodule

// File: rtl/gha_res_fifo.sv
module gha_res_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int PW   = gha_pkg::gha_bits(DEPTH),
    localparam int CW   = gha_pkg::gha_bits(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata
);

    localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] C_FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == P_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == P_LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];

    // R7: the buffer never takes more than SEGS entries
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |-> count != C_FULL);

    // R7: nothing is replayed from an empty buffer
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);

endmodule

// File: rtl/gha_seq_ctrl.sv
module gha_seq_ctrl import gha_pkg::*; #(
    parameter int NEURONS = 3,
    parameter int SEGS    = 4,
    parameter int DW      = 16,
    localparam int AW     = gha_bits(NEURONS * SEGS),
    localparam int KW     = gha_bits(SEGS),
    localparam int PHW    = gha_bits(NEURONS + 1),
    localparam int CW     = gha_bits(SEGS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           y_valid,
    input  logic [DW-1:0]  y_in,
    input  logic           res_valid,
    output logic           busy,
    output logic           done,
    output logic           rd_en,
    output logic [AW-1:0]  rd_addr,
    output logic           wr_en,
    output logic [AW-1:0]  wr_addr,
    output logic           push_en,
    output logic           s1_pcc,
    output logic           s1_upd,
    output logic [PHW-1:0] s1_ph,
    output logic [KW-1:0]  s1_k,
    output logic [DW-1:0]  y_upd
);

    localparam logic [PHW-1:0] PH_LAST  = PHW'(NEURONS);
    localparam logic [KW-1:0]  K_LAST   = KW'(SEGS - 1);
    localparam logic [CW-1:0]  CNT_FULL = CW'(SEGS);

    gha_state_e    st;
    gha_state_e    nxt;
    logic [PHW-1:0] ph;
    logic [KW-1:0]  k;
    logic [KW-1:0]  wr_k;
    logic [CW-1:0]  res_cnt;
    logic           y_have;
    logic [DW-1:0]  y_new;
    logic           s1_valid;
    logic           iss;
    logic           iss_pcc;
    logic           iss_upd;
    logic           drain_ok;
    logic           advance;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // next state and outputs
    always_comb begin
        nxt      = st;
        iss_pcc  = (ph != PH_LAST);
        iss_upd  = (ph != '0);
        drain_ok = !s1_valid
                   && (!iss_pcc || y_have)
                   && (!iss_upd || res_cnt == CNT_FULL);
        unique case (st)
            ST_IDLE:   if (start) nxt = ST_STREAM;
            ST_STREAM: if (k == K_LAST) nxt = ST_DRAIN;
            ST_DRAIN:  if (drain_ok) nxt = iss_pcc ? ST_STREAM : ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
        endcase
        busy    = (st != ST_IDLE);
        done    = (st == ST_FINISH);
        iss     = (st == ST_STREAM);
        advance = (st == ST_DRAIN) && drain_ok && iss_pcc;
        rd_en   = iss && iss_pcc;
        rd_addr = AW'(int'(ph) * SEGS + int'(k));
        wr_en   = res_valid && busy && iss_upd;
        wr_addr = AW'((int'(ph) - 1) * SEGS + int'(wr_k));
        push_en = wr_en && iss_pcc;
    end

    // counters, y hand-off and issue pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph       <= '0;
            k        <= '0;
            wr_k     <= '0;
            res_cnt  <= '0;
            y_have   <= 1'b0;
            y_new    <= '0;
            y_upd    <= '0;
            s1_valid <= 1'b0;
            s1_pcc   <= 1'b0;
            s1_upd   <= 1'b0;
            s1_ph    <= '0;
            s1_k     <= '0;
        end else begin
            s1_valid <= iss;
            s1_pcc   <= iss && iss_pcc;
            s1_upd   <= iss && iss_upd;
            s1_ph    <= ph;
            s1_k     <= k;
            if (st == ST_IDLE && start) begin
                ph      <= '0;
                k       <= '0;
                wr_k    <= '0;
                res_cnt <= '0;
                y_have  <= 1'b0;
            end
            if (iss) begin
                k <= (k == K_LAST) ? '0 : k + 1'b1;
            end
            if (y_valid && busy) begin
                y_new  <= y_in;
                y_have <= 1'b1;
            end
            if (wr_en) begin
                wr_k    <= wr_k + 1'b1;
                res_cnt <= res_cnt + 1'b1;
            end
            if (advance) begin
                ph      <= ph + 1'b1;
                y_upd   <= y_new;
                y_have  <= 1'b0;
                wr_k    <= '0;
                res_cnt <= '0;
            end
        end
    end

    // R9: done is a single-cycle pulse and the block is idle after it
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R3: every weight read is followed by a dot-product beat
    a_r3_rd_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> s1_pcc);

endmodule

// File: rtl/gha_iter_ctrl.sv
module gha_iter_ctrl import gha_pkg::*; #(
    parameter int NEURONS = 3,
    parameter int SEGS    = 4,
    parameter int LANES   = 2,
    parameter int DW      = 16,
    localparam int AW     = gha_bits(NEURONS * SEGS),
    localparam int KW     = gha_bits(SEGS),
    localparam int PHW    = gha_bits(NEURONS + 1),
    localparam int LW     = LANES * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           busy,
    output logic           done,
    input  logic           x_ld_en,
    input  logic [KW-1:0]  x_ld_seg,
    input  logic [LW-1:0]  x_ld_data,
    input  logic           w_ld_en,
    input  logic [AW-1:0]  w_ld_addr,
    input  logic [LW-1:0]  w_ld_data,
    output logic           dp_valid,
    output logic           dp_first,
    output logic           dp_last,
    output logic [PHW-1:0] dp_neuron,
    output logic [KW-1:0]  dp_seg,
    output logic [LW-1:0]  dp_x,
    output logic [LW-1:0]  dp_w,
    input  logic           dp_y_valid,
    input  logic [DW-1:0]  dp_y,
    output logic           up_valid,
    output logic [PHW-1:0] up_neuron,
    output logic [KW-1:0]  up_seg,
    output logic [LW-1:0]  up_z,
    output logic [LW-1:0]  up_w,
    output logic [DW-1:0]  up_y,
    input  logic           up_res_valid,
    input  logic [LW-1:0]  up_w_new,
    input  logic [LW-1:0]  up_z_new
);

    localparam logic [KW-1:0]  K_LAST = KW'(SEGS - 1);
    localparam logic [PHW-1:0] PH_ONE = PHW'(1);

    logic           rd_en;
    logic [AW-1:0]  rd_addr;
    logic           seq_wr_en;
    logic [AW-1:0]  seq_wr_addr;
    logic           push_en;
    logic           pop_en;
    logic           s1_pcc;
    logic           s1_upd;
    logic [PHW-1:0] s1_ph;
    logic [KW-1:0]  s1_k;
    logic [LW-1:0]  ram_rdata;
    logic [LW-1:0]  vec_seg;
    logic [LW-1:0]  fifo_head;
    logic           ram_we;
    logic [AW-1:0]  ram_waddr;
    logic [LW-1:0]  ram_wdata;
    logic [LW-1:0]  stage [2][SEGS];

    gha_seq_ctrl #(
        .NEURONS (NEURONS),
        .SEGS    (SEGS),
        .DW      (DW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .y_valid   (dp_y_valid),
        .y_in      (dp_y),
        .res_valid (up_res_valid),
        .busy      (busy),
        .done      (done),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .wr_en     (seq_wr_en),
        .wr_addr   (seq_wr_addr),
        .push_en   (push_en),
        .s1_pcc    (s1_pcc),
        .s1_upd    (s1_upd),
        .s1_ph     (s1_ph),
        .s1_k      (s1_k),
        .y_upd     (up_y)
    );

    // the write port serves preloads while idle and results while busy
    always_comb begin
        ram_we    = busy ? seq_wr_en   : w_ld_en;
        ram_waddr = busy ? seq_wr_addr : w_ld_addr;
        ram_wdata = busy ? up_w_new    : w_ld_data;
    end

    gha_wram #(
        .DEPTH (NEURONS * SEGS),
        .W     (LW)
    ) u_wram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (ram_rdata)
    );

    gha_vec_buf #(
        .LANES (LANES),
        .SEGS  (SEGS),
        .DW    (DW)
    ) u_vec (
        .clk   (clk),
        .we    (x_ld_en && !busy),
        .wseg  (x_ld_seg),
        .wdata (x_ld_data),
        .rseg  (s1_k),
        .rdata (vec_seg)
    );

    assign pop_en = s1_upd && (s1_ph > PH_ONE);

    gha_res_fifo #(
        .DEPTH (SEGS),
        .W     (LW)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_en),
        .wdata (up_z_new),
        .pop   (pop_en),
        .rdata (fifo_head)
    );

    // ping-pong copy of the weights read for the dot product, replayed for the update
    always_ff @(posedge clk) begin
        if (s1_pcc) begin
            stage[s1_ph[0]][s1_k] <= ram_rdata;
        end
    end

    always_comb begin
        dp_valid  = s1_pcc;
        dp_first  = (s1_k == '0);
        dp_last   = (s1_k == K_LAST);
        dp_neuron = s1_ph;
        dp_seg    = s1_k;
        dp_x      = vec_seg;
        dp_w      = ram_rdata;
        up_valid  = s1_upd;
        up_neuron = s1_ph - 1'b1;
        up_seg    = s1_k;
        up_w      = stage[~s1_ph[0]][s1_k];
        up_z      = (s1_ph == PH_ONE) ? vec_seg : fifo_head;
    end

    // R8: a result write never targets the neuron being read
    a_r8_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
        seq_wr_en && rd_en |-> (int'(seq_wr_addr) / SEGS) != (int'(rd_addr) / SEGS));

    // R4: y is held steady across an update stream
    a_r4_y_held: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && $past(up_valid) |-> $stable(up_y));

    // R5: an update beat always has a partner dot-product beat except in the final phase
    a_r5_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && (int'(up_neuron) < NEURONS - 1) |-> dp_valid);

endmodule

// File: tb/gha_iter_ctrl_tb.sv
`timescale 1ns/1ps
module gha_iter_ctrl_tb;
    import gha_pkg::*;

    localparam int P   = 3;
    localparam int B   = 4;
    localparam int Q   = 2;
    localparam int DW  = 16;
    localparam int FR  = 6;
    localparam int ETA = 10;
    localparam int AW  = gha_bits(P * B);
    localparam int KW  = gha_bits(B);
    localparam int PHW = gha_bits(P + 1);
    localparam int LW  = Q * DW;
    localparam int N   = B * Q;

    // rows: x seed, w seed, dot-product latency, update latency
    localparam int NROW = 4;
    localparam int TBL [NROW][4] = '{
        '{1, 2, 1, 1},
        '{5, 3, 3, 1},
        '{8, 7, 1, 3},
        '{4, 9, 2, 2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic           start = 1'b0;
    logic           busy, done;
    logic           x_ld_en = 1'b0;
    logic [KW-1:0]  x_ld_seg = '0;
    logic [LW-1:0]  x_ld_data = '0;
    logic           w_ld_en = 1'b0;
    logic [AW-1:0]  w_ld_addr = '0;
    logic [LW-1:0]  w_ld_data = '0;
    logic           dp_valid, dp_first, dp_last;
    logic [PHW-1:0] dp_neuron;
    logic [KW-1:0]  dp_seg;
    logic [LW-1:0]  dp_x, dp_w;
    logic           dp_y_valid;
    logic [DW-1:0]  dp_y;
    logic           up_valid;
    logic [PHW-1:0] up_neuron;
    logic [KW-1:0]  up_seg;
    logic [LW-1:0]  up_z, up_w;
    logic [DW-1:0]  up_y;
    logic           up_res_valid;
    logic [LW-1:0]  up_w_new, up_z_new;

    gha_iter_ctrl #(.NEURONS(P), .SEGS(B), .LANES(Q), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .x_ld_en(x_ld_en), .x_ld_seg(x_ld_seg), .x_ld_data(x_ld_data),
        .w_ld_en(w_ld_en), .w_ld_addr(w_ld_addr), .w_ld_data(w_ld_data),
        .dp_valid(dp_valid), .dp_first(dp_first), .dp_last(dp_last),
        .dp_neuron(dp_neuron), .dp_seg(dp_seg), .dp_x(dp_x), .dp_w(dp_w),
        .dp_y_valid(dp_y_valid), .dp_y(dp_y),
        .up_valid(up_valid), .up_neuron(up_neuron), .up_seg(up_seg),
        .up_z(up_z), .up_w(up_w), .up_y(up_y),
        .up_res_valid(up_res_valid), .up_w_new(up_w_new), .up_z_new(up_z_new)
    );

    int checks = 0;
    int errors = 0;
    int ylat = 1;
    int ulat = 1;

    function automatic logic signed [15:0] f_wn(int w, int y, int z);
        return 16'(w + ((y * z) >>> ETA));
    endfunction

    function automatic logic signed [15:0] f_zn(int w, int y, int z);
        return 16'(z - ((w * y) >>> FR));
    endfunction

    // arithmetic models of the two external units
    int acc;
    logic [3:0]    ypv;
    logic [DW-1:0] yp [4];
    always @(posedge clk) begin : pcc_model
        int s;
        s = dp_first ? 0 : acc;
        for (int l = 0; l < Q; l++)
            s += int'($signed(dp_x[l*DW +: DW])) * int'($signed(dp_w[l*DW +: DW]));
        if (dp_valid) acc <= s;
        if (!rst_n) ypv <= '0;
        else ypv <= {ypv[2:0], dp_valid && dp_last};
        yp[0] <= 16'(s >>> FR);
        for (int i = 1; i < 4; i++) yp[i] <= yp[i-1];
    end
    assign dp_y_valid = ypv[ylat-1];
    assign dp_y       = yp[ylat-1];

    logic [3:0]    upv;
    logic [LW-1:0] wnp [4];
    logic [LW-1:0] znp [4];
    always @(posedge clk) begin : upd_model
        logic [LW-1:0] wn, zn;
        for (int l = 0; l < Q; l++) begin
            wn[l*DW +: DW] = f_wn(int'($signed(up_w[l*DW +: DW])), int'($signed(up_y)),
                                  int'($signed(up_z[l*DW +: DW])));
            zn[l*DW +: DW] = f_zn(int'($signed(up_w[l*DW +: DW])), int'($signed(up_y)),
                                  int'($signed(up_z[l*DW +: DW])));
        end
        if (!rst_n) upv <= '0;
        else upv <= {upv[2:0], up_valid};
        wnp[0] <= wn;
        znp[0] <= zn;
        for (int i = 1; i < 4; i++) begin
            wnp[i] <= wnp[i-1];
            znp[i] <= znp[i-1];
        end
    end
    assign up_res_valid = upv[ulat-1];
    assign up_w_new     = wnp[ulat-1];
    assign up_z_new     = znp[ulat-1];

    // reference values
    logic signed [15:0] xv [N];
    logic signed [15:0] wv [P][N];
    logic signed [15:0] ex_y [P];
    logic signed [15:0] ex_z [P][N];
    logic signed [15:0] ex_wn [P][N];

    task automatic ref_compute();
        logic signed [15:0] z [N];
        for (int i = 0; i < N; i++) z[i] = xv[i];
        for (int j = 0; j < P; j++) begin
            int s;
            s = 0;
            for (int i = 0; i < N; i++) s += int'(xv[i]) * int'(wv[j][i]);
            ex_y[j] = 16'(s >>> FR);
            for (int i = 0; i < N; i++) begin
                ex_z[j][i]  = z[i];
                ex_wn[j][i] = f_wn(int'(wv[j][i]), int'(ex_y[j]), int'(z[i]));
                z[i]        = f_zn(int'(wv[j][i]), int'(ex_y[j]), int'(z[i]));
            end
        end
    endtask

    function automatic logic [LW-1:0] seg_of_x(int k);
        logic [LW-1:0] v;
        for (int l = 0; l < Q; l++) v[l*DW +: DW] = xv[k*Q + l];
        return v;
    endfunction

    function automatic logic [LW-1:0] seg_of_w(int j, int k);
        logic [LW-1:0] v;
        for (int l = 0; l < Q; l++) v[l*DW +: DW] = wv[j][k*Q + l];
        return v;
    endfunction

    function automatic logic [LW-1:0] seg_of_z(int j, int k);
        logic [LW-1:0] v;
        for (int l = 0; l < Q; l++) v[l*DW +: DW] = ex_z[j][k*Q + l];
        return v;
    endfunction

    // monitor
    int dp_idx, up_idx, mm_dx, mm_dw, mm_flag, mm_uz, mm_uy, mm_ord, ov_cnt;
    int done_cnt, done_wide, y_cnt;
    logic done_prev = 1'b0;

    task automatic clear_mon();
        dp_idx = 0; up_idx = 0; mm_dx = 0; mm_dw = 0; mm_flag = 0; mm_uz = 0;
        mm_uy = 0; mm_ord = 0; ov_cnt = 0; done_cnt = 0; done_wide = 0; y_cnt = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (dp_valid) begin
                if (int'(dp_neuron) != dp_idx / B || int'(dp_seg) != dp_idx % B
                    || dp_first != (dp_idx % B == 0) || dp_last != (dp_idx % B == B - 1))
                    mm_flag++;
                if (dp_x !== seg_of_x(int'(dp_seg))) mm_dx++;
                if (dp_w !== seg_of_w(int'(dp_neuron), int'(dp_seg))) mm_dw++;
                dp_idx++;
            end
            if (up_valid) begin
                if (int'(up_neuron) != up_idx / B || int'(up_seg) != up_idx % B) mm_ord++;
                if (y_cnt <= int'(up_neuron)) mm_ord++;
                if (up_z !== seg_of_z(int'(up_neuron), int'(up_seg))) mm_uz++;
                if (up_y !== ex_y[up_neuron]) mm_uy++;
                if (up_w !== seg_of_w(int'(up_neuron), int'(up_seg))) mm_uy++;
                up_idx++;
            end
            if (dp_valid && up_valid && int'(dp_neuron) == int'(up_neuron) + 1
                && dp_seg == up_seg)
                ov_cnt++;
            if (dp_y_valid) y_cnt++;
            if (done) done_cnt++;
            if (done && done_prev) done_wide++;
            done_prev <= done;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_all();
        for (int k = 0; k < B; k++) begin
            @(negedge clk);
            x_ld_en = 1'b1; x_ld_seg = KW'(k); x_ld_data = seg_of_x(k);
        end
        @(negedge clk);
        x_ld_en = 1'b0;
        for (int j = 0; j < P; j++)
            for (int k = 0; k < B; k++) begin
                w_ld_en = 1'b1; w_ld_addr = AW'(j * B + k); w_ld_data = seg_of_w(j, k);
                @(negedge clk);
            end
        w_ld_en = 1'b0;
    endtask

    task automatic run_iter(bit meddle);
        int t;
        clear_mon();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (done_cnt == 0 && t < 3000) begin
            @(negedge clk);
            t++;
            if (meddle && t == 6) begin
                start = 1'b1;
                x_ld_en = 1'b1; x_ld_seg = '0; x_ld_data = {LW{1'b1}};
                w_ld_en = 1'b1; w_ld_addr = AW'(B); w_ld_data = '0;
            end else begin
                start = 1'b0; x_ld_en = 1'b0; w_ld_en = 1'b0;
            end
        end
        check(done_cnt > 0, "R9", "iteration finished", done_cnt, 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic iter_checks(string wreq);
        check(mm_flag == 0, "R3", "dp order/first/last mismatches", mm_flag, 0);
        check(mm_dx == 0, "R3", "dp_x mismatches", mm_dx, 0);
        check(mm_dw == 0, wreq, "dp_w mismatches", mm_dw, 0);
        check(dp_idx == P * B, "R3", "dp beats", dp_idx, P * B);
        check(mm_ord == 0 && mm_uy == 0, "R4", "update order/y/w mismatches",
              mm_ord + mm_uy, 0);
        check(mm_uz == 0, "R6", "residual mismatches", mm_uz, 0);
        check(up_idx == P * B, "R7", "update beats", up_idx, P * B);
        check(ov_cnt == (P - 1) * B, "R5", "overlapped beats", ov_cnt, (P - 1) * B);
        check(done_cnt == 1 && done_wide == 0 && !busy, "R9", "done pulses",
              done_cnt * 10 + done_wide, 10);
    endtask

    initial begin : watchdog
        #750000;
        errors++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !dp_valid && !up_valid, "R1", "outputs in reset",
              int'({busy, done, dp_valid, up_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !dp_valid && !up_valid, "R1", "outputs after reset",
              int'({busy, done, dp_valid, up_valid}), 0);

        for (int r = 0; r < NROW; r++) begin
            ylat = TBL[r][2];
            ulat = TBL[r][3];
            for (int i = 0; i < N; i++) begin
                xv[i] = 16'(((TBL[r][0] * 7 + i * 13) % 41) - 20);
                for (int j = 0; j < P; j++)
                    wv[j][i] = 16'(((TBL[r][1] * 11 + j * 17 + i * 5) % 129) - 64);
            end
            load_all();
            ref_compute();
            run_iter(1'b0);
            iter_checks("R10");
            for (int j = 0; j < P; j++)
                for (int i = 0; i < N; i++) wv[j][i] = ex_wn[j][i];
            ref_compute();
            run_iter(1'b0);
            iter_checks("R8");
        end

        // R2: start and loads while busy are ignored
        ylat = 2; ulat = 1;
        for (int i = 0; i < N; i++) begin
            xv[i] = 16'(((3 * 7 + i * 13) % 41) - 20);
            for (int j = 0; j < P; j++) wv[j][i] = 16'(((6 * 11 + j * 17 + i * 5) % 129) - 64);
        end
        load_all();
        ref_compute();
        run_iter(1'b1);
        check(mm_dx == 0 && mm_dw == 0, "R2", "stream disturbed by busy loads",
              mm_dx + mm_dw, 0);
        check(done_cnt == 1, "R2", "done pulses with start while busy", done_cnt, 1);
        clear_mon();
        repeat (10) @(negedge clk);
        check(!busy && done_cnt == 0, "R2", "restart after busy start",
              int'(busy) + done_cnt, 0);
        for (int j = 0; j < P; j++)
            for (int i = 0; i < N; i++) wv[j][i] = ex_wn[j][i];
        ref_compute();
        run_iter(1'b0);
        check(mm_dx == 0, "R2", "training vector after busy load", mm_dx, 0);
        check(mm_dw == 0, "R2", "weights after busy preload", mm_dw, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule